// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog counter for a processor subsystem. Software programs a reload value, a prescaler setting and a set of expiry actions into a control register, then enables the counter. The counter steps down once per prescaled tick. If software does not restart it in time, the counter expires. An expiry can raise a level interrupt, drive an active-low overflow pin for a fixed number of clocks, issue a one-clock reset request, or any mix of these. After an expiry the counter reloads itself and keeps running.

A stray or runaway write must not be able to silence or feed the watchdog. For that reason, every write to a mapped register must carry a fixed key in its top byte. A write whose key does not match changes nothing except a sticky error flag. The bus is a plain single-cycle register port: address, write data and write strobe, with read data returned combinationally.

Top module: `kwdt_top`

## Requirements
- R1: After reset the watchdog is disabled. Reads of the control word (address 0), the count (address 1) and the status (address 2) all return 0. The overflow pin is high, and the interrupt and reset request are low.
- R2: A write to address 0, 1 or 2 is accepted only when write-data bits [31:24] equal the key 0x5A. The control word layout is: reload value in bits [15:0], enable in bit 16, interrupt action in bit 17, pin action in bit 18, reset action in bit 19, prescaler select in bits [22:20].
- R3: A keyed control write loads the counter with the new reload value R, and the count reads back R right after that write. With prescaler select s, the watchdog expires exactly (R+1)*2^s clocks after the write edge. On expiry the counter reloads R.
- R4: A write to a mapped address with a wrong key leaves the control word and the count unchanged. It sets the sticky key-error flag, which is status bit 1.
- R5: When the reset action is on, each expiry produces a reset request that is high for exactly one clock.
- R6: When the pin action is on, the overflow pin goes low in the cycle after the expiry edge and stays low for 8 clocks. When the pin action is off, the pin stays high.
- R7: The interrupt is high while the expired flag (status bit 0) is set and the interrupt action is on. It drops when the flag is cleared.
- R8: A keyed write to address 1 reloads the counter from the stored reload value. Restarting often enough means the watchdog never expires.
- R9: A keyed write to address 2 clears the expired flag if bit 0 is set and the key-error flag if bit 1 is set. A new expiry or bad write in the same cycle takes priority over the clear.
- R10: While the watchdog is disabled, the count holds its value and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data, key in top byte |
| bus_rdata | output | 32 | Read data for bus_addr |
| wd_irq | output | 1 | Expiry interrupt, level |
| wd_ovf_n | output | 1 | Overflow pin, active low |
| wd_rst_req | output | 1 | Reset request pulse |

## Verification
The assertions assume that the write strobe and address are valid on every clock edge and that the key byte is stable during a write cycle. They also assume the reset action and pin action change only through keyed control writes. The stimulus drives each write for exactly one clock between falling edges. Once an expiry is seen, the stimulus disables the watchdog within one clock, so pulse widths are measured without retriggering. Random reload values, prescaler settings and action masks are drawn from a fixed seed and mixed with directed cases: zero reload, full-range reload, wrong keys and disabled operation.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam int KEY_LSB   = 24;
   localparam int KEY_W     = 8;
   localparam int F_EN      = 16;
   localparam int F_IRQ     = 17;
   localparam int F_PIN     = 18;
   localparam int F_RST     = 19;
   localparam int F_SEL_LSB = 20;
   localparam int RELOAD_FIELD_W = 16;
   localparam int SEL_FIELD_W    = 3;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_KICK = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;

   typedef struct packed {
      logic rst_en;
      logic pin_en;
      logic irq_en;
   } kwdt_act_t;
endpackage

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PRE_W = (1 << SEL_W) - 1;

   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] limit;

   // limit = 2^sel - 1, so a tick comes every 2^sel clocks
   assign limit = ~({PRE_W{1'b1}} << sel);
   assign tick  = (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   assign count  = cnt_q;
   assign expire = en && tick && !load && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (en && tick)
         cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
   end
endmodule

// File: rtl/kwdt_stretch.sv
module kwdt_stretch #(
   parameter int LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active
);
   generate
      if (LEN == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= trig;
         end
         assign active = q;
      end else begin : g_multi
         localparam int CW = $clog2(LEN + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt_q <= '0;
            else if (trig)        cnt_q <= CW'(LEN);
            else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         end
         assign active = (cnt_q != '0);
      end
   endgenerate
endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
   import kwdt_pkg::*;
#(
   parameter int          CNT_W = 16,
   parameter int          SEL_W = 3,
   parameter logic [7:0]  KEY   = 8'h5A
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [1:0]       addr,
   input  logic [31:0]      wdata,
   input  logic [CNT_W-1:0] count,
   input  logic             expire,
   output logic             en,
   output kwdt_act_t        act,
   output logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] reload,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             expired,
   output logic             keyerr,
   output logic [31:0]      rdata
);
   logic key_ok, mapped, wr_good, wr_bad;
   logic clr_exp, clr_err;
   logic unused_wdata;

   assign unused_wdata = ^wdata;
   assign key_ok  = (wdata[KEY_LSB +: KEY_W] == KEY);
   assign mapped  = (addr != 2'd3);
   assign wr_good = wr && mapped && key_ok;
   assign wr_bad  = wr && mapped && !key_ok;
   assign clr_exp = wr_good && (addr == A_STAT) && wdata[0];
   assign clr_err = wr_good && (addr == A_STAT) && wdata[1];

   assign load     = wr_good && ((addr == A_CTRL) || (addr == A_KICK));
   assign load_val = (addr == A_CTRL) ? wdata[CNT_W-1:0] : reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         act    <= '0;
         sel    <= '0;
         reload <= '0;
      end else if (wr_good && (addr == A_CTRL)) begin
         en         <= wdata[F_EN];
         act.irq_en <= wdata[F_IRQ];
         act.pin_en <= wdata[F_PIN];
         act.rst_en <= wdata[F_RST];
         sel        <= wdata[F_SEL_LSB +: SEL_W];
         reload     <= wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         expired <= 1'b0;
         keyerr  <= 1'b0;
      end else begin
         if (expire)       expired <= 1'b1;
         else if (clr_exp) expired <= 1'b0;
         if (wr_bad)       keyerr  <= 1'b1;
         else if (clr_err) keyerr  <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_CTRL: begin
            rdata[CNT_W-1:0]             = reload;
            rdata[F_EN]                  = en;
            rdata[F_IRQ]                 = act.irq_en;
            rdata[F_PIN]                 = act.pin_en;
            rdata[F_RST]                 = act.rst_en;
            rdata[F_SEL_LSB +: SEL_W]    = sel;
         end
         A_KICK:  rdata[CNT_W-1:0] = count;
         A_STAT:  rdata[1:0]       = {keyerr, expired};
         default: rdata            = '0;
      endcase
   end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int         CNT_W     = 16,
   parameter int         SEL_W     = 3,
   parameter int         PULSE_LEN = 8,
   parameter logic [7:0] KEY       = 8'h5A
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        wd_irq,
   output logic        wd_ovf_n,
   output logic        wd_rst_req
);
   generate
      if (CNT_W < 1 || CNT_W > RELOAD_FIELD_W) begin : g_bad_cnt
         $error("kwdt_top: CNT_W must be 1..16");
      end
      if (SEL_W < 1 || SEL_W > SEL_FIELD_W) begin : g_bad_sel
         $error("kwdt_top: SEL_W must be 1..3");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         $error("kwdt_top: PULSE_LEN must be at least 1");
      end
   endgenerate

   logic             en_w, load_w, tick_w, expire_w;
   logic             expired_w, keyerr_w, pin_active_w;
   kwdt_act_t        act_w;
   logic [SEL_W-1:0] sel_w;
   logic [CNT_W-1:0] reload_w, load_val_w, count_w;
   logic             rst_q;

   kwdt_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .KEY(KEY)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .count(count_w), .expire(expire_w), .en(en_w), .act(act_w), .sel(sel_w),
      .reload(reload_w), .load(load_w), .load_val(load_val_w),
      .expired(expired_w), .keyerr(keyerr_w), .rdata(bus_rdata)
   );

   kwdt_prescale #(.SEL_W(SEL_W)) pre_i (
      .clk(clk), .rst_n(rst_n), .clr(load_w || !en_w), .sel(sel_w), .tick(tick_w)
   );

   kwdt_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .en(en_w), .tick(tick_w), .load(load_w),
      .load_val(load_val_w), .reload(reload_w), .count(count_w), .expire(expire_w)
   );

   kwdt_stretch #(.LEN(PULSE_LEN)) pin_i (
      .clk(clk), .rst_n(rst_n), .trig(expire_w && act_w.pin_en), .active(pin_active_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= 1'b0;
      else        rst_q <= expire_w && act_w.rst_en;
   end

   assign wd_rst_req = rst_q;
   assign wd_ovf_n   = !pin_active_w;
   assign wd_irq     = expired_w && act_w.irq_en;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
   parameter int         CNT_W = 16,
   parameter logic [7:0] KEY   = 8'h5A
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr,
   input logic [1:0]       addr,
   input logic [7:0]       key,
   input logic             ovf_n,
   input logic             rst_req,
   input logic             expired,
   input logic             keyerr,
   input logic             en,
   input logic             pin_en,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] reload
);
   // R4: a wrong key raises the error flag and leaves enable untouched
   a_r4_bad_key_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr != 2'd3 && key != KEY) |=> keyerr);
   a_r4_bad_key_no_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr != 2'd3 && key != KEY) |=> $stable(en));
   // R3: the count never exceeds the programmed reload value
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= reload);
   // R5: a reset request only accompanies a latched expiry
   a_r5_rst_with_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> expired);
   // R6: a fresh expiry with pin action drives the pin low
   a_r6_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(expired) && pin_en) |-> !ovf_n);
   // R10: a disabled counter with no bus write holds still
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wr) |=> $stable(count));
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W), .KEY(KEY)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .key(bus_wdata[31:24]),
   .ovf_n(wd_ovf_n), .rst_req(wd_rst_req), .expired(expired_w), .keyerr(keyerr_w),
   .en(en_w), .pin_en(act_w.pin_en), .count(count_w), .reload(reload_w)
);

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
   localparam int         CLK_PERIOD = 10;
   localparam int         PLEN       = 8;
   localparam logic [7:0] KEY        = 8'h5A;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr;
   logic [1:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        irq, ovf_n, rst_req;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   kwdt_top #(.CNT_W(16), .SEL_W(3), .PULSE_LEN(PLEN), .KEY(KEY)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(rdata), .wd_irq(irq), .wd_ovf_n(ovf_n), .wd_rst_req(rst_req)
   );

   function automatic logic [31:0] f_ctrl(input logic [7:0] k, input int r, input bit e,
                                          input bit i, input bit p, input bit x, input int s);
      logic [31:0] w;
      w = '0;
      w[31:24] = k; w[22:20] = s[2:0]; w[19] = x; w[18] = p; w[17] = i; w[16] = e;
      w[15:0] = r[15:0];
      return w;
   endfunction

   function automatic int f_exp(input int r, input int s);
      return (r + 1) << s;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0; #1;
   endtask

   task automatic read_at(input logic [1:0] a);
      addr = a; #1;
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic run_expire(input int r, input int s, input bit i, input bit p, input bit x);
      int elapsed, low;
      bus_write(2'd0, f_ctrl(KEY, r, 1, i, p, x, s));
      read_at(2'd1);
      check("R3 count after load", rdata, r);
      read_at(2'd2);
      elapsed = 0;
      while (!rdata[0] && elapsed < 70000) begin
         @(negedge clk); #1; elapsed++;
      end
      check("R3 expiry time", elapsed, f_exp(r, s));
      check("R7 irq at expiry", irq, i);
      check("R5 reset request", rst_req, x);
      check("R6 pin at expiry", ovf_n, !p);
      low = ovf_n ? 0 : 1;
      wr = 1'b1; addr = 2'd0; wdata = f_ctrl(KEY, r, 0, i, p, x, s);
      @(negedge clk); wr = 1'b0; #1;
      check("R5 one clock", rst_req, 0);
      if (!ovf_n) low++;
      for (int k = 0; k < PLEN + 3; k++) begin
         @(negedge clk); #1; if (!ovf_n) low++;
      end
      check("R6 pulse width", low, p ? PLEN : 0);
      check("R7 irq held", irq, i);
      bus_write(2'd2, {KEY, 24'h000001});
      read_at(2'd2);
      check("R9 expired cleared", rdata[0], 0);
      check("R7 irq dropped", irq, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; wr = 1'b0; addr = 2'd0; wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; #1;

      // R1 reset state
      read_at(2'd0); check("R1 ctrl", rdata, 0);
      read_at(2'd1); check("R1 count", rdata, 0);
      read_at(2'd2); check("R1 status", rdata, 0);
      check("R1 pin", ovf_n, 1);
      check("R1 irq", irq, 0);
      check("R1 rst", rst_req, 0);

      // R4 / R2 wrong key is discarded
      bus_write(2'd0, f_ctrl(8'h33, 3, 1, 1, 1, 1, 0));
      read_at(2'd0); check("R4 ctrl unchanged", rdata, 0);
      read_at(2'd2); check("R4 key error set", rdata, 32'h2);
      repeat (20) @(negedge clk); #1;
      check("R4 no expiry after bad write", rdata, 32'h2);
      bus_write(2'd2, {KEY, 24'h000002});
      read_at(2'd2); check("R9 key error cleared", rdata, 0);

      // R2 keyed control write reads back with fields in place
      bus_write(2'd0, f_ctrl(KEY, 16'h1234, 0, 1, 0, 1, 5));
      read_at(2'd0); check("R2 ctrl layout", rdata, 32'h005A_1234);

      // R10 disabled counter holds
      bus_write(2'd0, f_ctrl(KEY, 5, 0, 1, 1, 1, 0));
      repeat (50) @(negedge clk);
      read_at(2'd2); check("R10 no expiry", rdata, 0);
      read_at(2'd1); check("R10 count held", rdata, 5);

      // R8 restarts keep it alive
      bus_write(2'd0, f_ctrl(KEY, 30, 1, 1, 1, 1, 0));
      for (int k = 0; k < 10; k++) begin
         repeat (20) @(negedge clk);
         bus_write(2'd1, {KEY, 24'h0});
      end
      read_at(2'd2); check("R8 no expiry with restarts", rdata, 0);
      read_at(2'd1); check("R8 restart reloads", rdata, 30);
      repeat (10) @(negedge clk);
      bus_write(2'd1, {8'hA5, 24'h0});
      read_at(2'd1); check("R4 bad restart ignored", rdata, 30 - 12);
      bus_write(2'd1, {KEY, 24'h0});
      read_at(2'd1); check("R8 keyed restart", rdata, 30);
      bus_write(2'd0, f_ctrl(KEY, 30, 0, 0, 0, 0, 0));
      bus_write(2'd2, {KEY, 24'h000003});
      read_at(2'd2); check("R9 status clear", rdata, 0);

      // directed expiry corners
      run_expire(0, 0, 1, 1, 1);
      run_expire(3, 2, 0, 1, 0);
      run_expire(9, 1, 1, 0, 0);
      run_expire(2, 3, 0, 0, 1);
      run_expire(16'hFFFF, 0, 1, 1, 1);

      // constrained random
      for (int n = 0; n < 30; n++) begin
         int r, s;
         logic [2:0] m;
         r = $urandom_range(0, 40);
         s = $urandom_range(0, 3);
         m = 3'($urandom_range(0, 7));
         run_expire(r, s, m[0], m[1], m[2]);
      end

      summary();
      $finish;
   end
endmodule